// File: doc/BRIEF.md
# Phase-Accumulator Clock Output Generator

This block makes a programmable frequency for an output pin. On every system clock a phase register of `ACC_W` bits (32 by default) is advanced by an increment word. The output is then shaped into a two-bit word per clock, `{first_half, second_half}`. A double-data-rate pad stage, which lies outside this block, sends the first half while the system clock is high and the second half while it is low.

Two output shapes are available.

- **Standard shape.** Both halves carry the top bit of the phase register. The output frequency is `incr / 2^ACC_W` times the clock. Requests above half the clock rate fold back to lower frequencies.
- **Extended shape.** Each carry out of the phase addition becomes a pulse that lasts only the high half of that clock. Every frequency up to the full clock rate is then reproduced at its true value. The pulses get shorter; the block never produces a clock faster than the system clock.

Software-facing logic selects the increment and the shape, and can clear the phase at any time.

Top module: `nco_clkgen`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first clock with a non-zero increment, `out_word` is 2'b00 and the phase register is zero.
- R2: On each rising clock edge where `clear` is 0 and `incr` is non-zero, the phase register becomes (phase + incr) mod 2^ACC_W.
- R3: In the standard shape (`ext_mode` sampled as 0), `out_word` after an edge holds the new phase's top bit in both bit 1 and bit 0.
- R4: An increment of 0x8000_0000 makes the output high on every other clock, which is exactly half the clock frequency, in both shapes.
- R5: In the standard shape, increments above 0x8000_0000 alias downward. Starting from a cleared phase, 0xA000_0000 gives 3 rising edges of `out_word[1]` in 8 clocks.
- R6: In the extended shape (`ext_mode` sampled as 1), `out_word[1]` after an edge is the carry out of that edge's addition and `out_word[0]` is 0. Starting from zero phase, 0xA000_0000 gives 5 pulses in 8 clocks and 0xF000_0000 gives 15 pulses in 16 clocks.
- R7: An edge with `incr` equal to zero leaves the phase unchanged and drives `out_word` to 2'b00. The phase resumes from the held value afterwards.
- R8: A new increment is used from the next edge on, and the phase is not reset.
- R9: `clear` high at an edge sets the phase to zero and `out_word` to 2'b00, whatever the increment is.
- R10: A change of `ext_mode` changes the shape from the next edge on and leaves the phase untouched. With parameter `HAS_EXT` = 0, `ext_mode` is ignored and the standard shape is always used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Sets the phase register to zero at the next edge |
| ext_mode | input | 1 | 1 selects the extended (half-clock pulse) shape |
| incr | input | ACC_W | Phase increment added on every clock |
| out_word | output | 2 | {first_half, second_half} for the DDR pad stage |

## Verification
A corrupted phase register cannot be seen directly. It shows up as a shifted pattern of `out_word`, and only when a later addition carries or flips the top bit. For small increments that can take many clocks, so the reference model compares `out_word` on every single clock. The tests also use increments whose patterns repeat within 8 or 16 clocks, so a phase error changes the pulse count inside one test window. A wrong shape selection or a late mode change shows on the very next clock, as unequal halves in the standard shape or a set low half in the extended shape.

// File: rtl/nco_pkg.sv
package nco_pkg;

   typedef enum logic {
      SHAPE_STD = 1'b0,
      SHAPE_EXT = 1'b1
   } nco_shape_e;

   // Forms the two-phase output word from the registered event flags
   function automatic logic [1:0] form_word(input logic live,
                                            input logic cy,
                                            input logic top,
                                            input nco_shape_e shape);
      logic [1:0] w;
      if (!live)                   w = 2'b00;
      else if (shape == SHAPE_EXT) w = {cy, 1'b0};
      else                         w = {top, top};
      return w;
   endfunction

endpackage

// File: rtl/nco_seg_adder.sv
module nco_seg_adder #(
   parameter int ACC_W = 32,
   parameter int SEG_W = 8
) (
   input  logic [ACC_W-1:0] a,
   input  logic [ACC_W-1:0] b,
   output logic [ACC_W-1:0] sum,
   output logic             cout
);
   localparam int NSEG = ACC_W / SEG_W;

   logic [NSEG:0] cy;
   assign cy[0] = 1'b0;

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic [SEG_W:0] s_lo;
      logic [SEG_W:0] s_hi;
      assign s_lo = {1'b0, a[g*SEG_W +: SEG_W]} + {1'b0, b[g*SEG_W +: SEG_W]};
      assign s_hi = {1'b0, a[g*SEG_W +: SEG_W]} + {1'b0, b[g*SEG_W +: SEG_W]}
                    + (SEG_W+1)'(1);
      assign sum[g*SEG_W +: SEG_W] = cy[g] ? s_hi[SEG_W-1:0] : s_lo[SEG_W-1:0];
      assign cy[g+1]               = cy[g] ? s_hi[SEG_W]     : s_lo[SEG_W];
   end

   assign cout = cy[NSEG];
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int ACC_W = 32,
   parameter int SEG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [ACC_W-1:0] incr,
   output logic [ACC_W-1:0] phase_q,
   output logic             live_q,
   output logic             carry_q,
   output logic             top_q
);
   logic [ACC_W-1:0] sum_d;
   logic             cout_d;

   nco_seg_adder #(.ACC_W(ACC_W), .SEG_W(SEG_W)) u_add (
      .a    (phase_q),
      .b    (incr),
      .sum  (sum_d),
      .cout (cout_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         phase_q <= '0;
         live_q  <= 1'b0;
         carry_q <= 1'b0;
         top_q   <= 1'b0;
      end else if (incr != '0) begin
         phase_q <= sum_d;
         live_q  <= 1'b1;
         carry_q <= cout_d;
         top_q   <= sum_d[ACC_W-1];
      end else begin
         live_q  <= 1'b0;
         carry_q <= 1'b0;
         top_q   <= 1'b0;
      end
   end
endmodule

// File: rtl/nco_shape_sel.sv
module nco_shape_sel #(
   parameter bit HAS_EXT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ext_mode,
   output nco_pkg::nco_shape_e shape_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)                  shape_q <= nco_pkg::SHAPE_STD;
      else if (HAS_EXT && ext_mode) shape_q <= nco_pkg::SHAPE_EXT;
      else                         shape_q <= nco_pkg::SHAPE_STD;
   end
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
   parameter int ACC_W   = 32,
   parameter int SEG_W   = 8,
   parameter bit HAS_EXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             ext_mode,
   input  logic [ACC_W-1:0] incr,
   output logic [1:0]       out_word
);
   if (ACC_W < 2) begin : g_bad_width
      $error("nco_clkgen: ACC_W must be at least 2");
   end
   if (SEG_W < 1 || SEG_W > ACC_W || (ACC_W % SEG_W) != 0) begin : g_bad_seg
      $error("nco_clkgen: SEG_W must divide ACC_W");
   end

   logic [ACC_W-1:0]    phase_q;
   logic                live_q;
   logic                carry_q;
   logic                top_q;
   nco_pkg::nco_shape_e shape_q;

   nco_phase_acc #(.ACC_W(ACC_W), .SEG_W(SEG_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .incr    (incr),
      .phase_q (phase_q),
      .live_q  (live_q),
      .carry_q (carry_q),
      .top_q   (top_q)
   );

   nco_shape_sel #(.HAS_EXT(HAS_EXT)) u_shape (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_mode (ext_mode),
      .shape_q  (shape_q)
   );

   assign out_word = nco_pkg::form_word(live_q, carry_q, top_q, shape_q);
endmodule

// File: rtl/nco_clkgen_chk.sv
module nco_clkgen_chk #(
   parameter int ACC_W   = 32,
   parameter bit HAS_EXT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic             ext_mode,
   input logic [ACC_W-1:0] incr,
   input logic [1:0]       out_word,
   input logic [ACC_W-1:0] phase_q
);
   logic seen;
   always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // R2: phase advances by the sampled increment
   a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !$past(clear) && $past(incr) != '0)
         |-> phase_q == ACC_W'($past(phase_q) + $past(incr)));

   // R3: standard shape repeats one level in both halves
   a_r3_std_halves: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !(HAS_EXT && $past(ext_mode))) |-> out_word[1] == out_word[0]);

   // R6: extended shape never drives the low half
   a_r6_ext_low_half: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && HAS_EXT && $past(ext_mode)) |-> out_word[0] == 1'b0);

   // R7: a zero increment holds the phase and silences the output
   a_r7_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !$past(clear) && $past(incr) == '0)
         |-> (phase_q == $past(phase_q) && out_word == 2'b00));

   // R9: clear zeroes phase and output
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(clear)) |-> (phase_q == '0 && out_word == 2'b00));
endmodule

bind nco_clkgen nco_clkgen_chk #(.ACC_W(ACC_W), .HAS_EXT(HAS_EXT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clear    (clear),
   .ext_mode (ext_mode),
   .incr     (incr),
   .out_word (out_word),
   .phase_q  (phase_q)
);

// File: tb/sim_nco_clkgen.sv
`timescale 1ns/1ps
module sim_nco_clkgen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear = 1'b0;
   logic        ext_mode = 1'b0;
   logic [31:0] incr = 32'h0;
   logic [1:0]  out_word;

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";
   longint unsigned ref_phase = 0;
   logic  prev_hi = 1'b0;
   int    rises = 0;
   int    pulses = 0;

   always #4 clk = ~clk;

   nco_clkgen u0 (
      .clk(clk), .rst_n(rst_n), .clear(clear), .ext_mode(ext_mode),
      .incr(incr), .out_word(out_word)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Drive one clock at the negedge, model the edge, compare at the next negedge
   task automatic step(input logic c, input logic e, input logic [31:0] inc);
      longint unsigned s;
      logic [1:0] exp;
      clear = c; ext_mode = e; incr = inc;
      if (c) begin
         ref_phase = 0; exp = 2'b00;
      end else if (inc == 0) begin
         exp = 2'b00;
      end else begin
         s = ref_phase + longint'(inc);
         ref_phase = s & 64'hFFFF_FFFF;
         if (e) exp = {s[32], 1'b0};
         else   exp = {ref_phase[31], ref_phase[31]};
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, {30'h0, out_word}, {30'h0, exp});
      if (out_word[1] && !prev_hi) rises++;
      if (out_word[1]) pulses++;
      prev_hi = out_word[1];
   endtask

   task automatic window_reset();
      rises = 0; pulses = 0; prev_hi = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", {30'h0, out_word}, 32'h0);
      rst_n = 1'b1;
      tag = "R1";
      step(0, 0, 32'h0);
      step(0, 0, 32'h0);

      // R2 / R3: general increment, standard shape
      tag = "R2";
      for (int i = 0; i < 40; i++) step(0, 0, 32'h1234_5678);
      tag = "R3";
      for (int i = 0; i < 40; i++) step(0, 0, 32'h6F00_0001);

      // R4: half-rate in both shapes
      tag = "R4";
      step(1, 0, 32'h0);
      window_reset();
      for (int i = 0; i < 8; i++) step(0, 0, 32'h8000_0000);
      check("R4", pulses, 4);
      step(1, 1, 32'h0);
      window_reset();
      for (int i = 0; i < 8; i++) step(0, 1, 32'h8000_0000);
      check("R4", pulses, 4);

      // R5: aliasing in the standard shape
      tag = "R5";
      step(1, 0, 32'h0);
      window_reset();
      for (int i = 0; i < 8; i++) step(0, 0, 32'hA000_0000);
      check("R5", rises, 3);

      // R6: extended shape follows the true rate
      tag = "R6";
      step(1, 1, 32'h0);
      window_reset();
      for (int i = 0; i < 8; i++) step(0, 1, 32'hA000_0000);
      check("R6", pulses, 5);
      step(1, 1, 32'h0);
      window_reset();
      for (int i = 0; i < 16; i++) step(0, 1, 32'hF000_0000);
      check("R6", pulses, 15);

      // R7: zero increment freezes the phase
      tag = "R7";
      step(1, 0, 32'h0);
      step(0, 0, 32'h4000_0000);
      for (int i = 0; i < 3; i++) step(0, 0, 32'h0);
      step(0, 0, 32'h4000_0000);
      check("R7", {30'h0, out_word}, 32'h3);

      // R8: increment change keeps the phase
      tag = "R8";
      for (int i = 0; i < 5; i++) step(0, 0, 32'h0300_0000);
      for (int i = 0; i < 10; i++) step(0, 0, 32'h2900_0000);

      // R9: clear wins over a live increment
      tag = "R9";
      step(1, 1, 32'hFFFF_FFFF);
      step(0, 1, 32'hFFFF_FFFF);
      step(1, 0, 32'h9000_0000);
      step(0, 0, 32'h9000_0000);

      // R10: shape switches on the next edge, phase untouched
      tag = "R10";
      for (int i = 0; i < 24; i++) step(0, i[1], 32'hC300_0000);

      finish_run();
   end
endmodule